// File: doc/BRIEF.md
# Addressed SPI Memory Access Engine

This block is an SPI slave that turns byte frames from a host into reads and writes on a simple synchronous memory port. The port covers an 11-bit byte address space. The first byte of every chip-select frame is an opcode. Its top five bits choose one of four access styles, and its low three bits carry address bits [10:8]. The second byte always carries address bits [7:0].

In the two block styles the engine steps the address by one per data byte and keeps streaming until chip-select rises. In the two random styles the host sends a fresh low-address byte before every data byte, and the upper bits stay at the value taken from the opcode. Reads put one dummy byte between the address and the first data byte, which gives the memory time to answer. The SPI pins are oversampled in the system clock domain, so SCLK must run well below the system clock (at least eight system clocks per SCLK phase).

The host owns the mapping of the address space onto regions and the length limit for each region. Typical limits are 256 bytes for the control-register and packet regions and 64 bytes for the battery-backed region. The engine checks neither.

Top module: `spi_mem_engine`

## Requirements
- R1: SPI mode 0, MSB first: MOSI is taken on the rising SCLK edge and MISO changes after the falling edge. In the first byte of a frame, bits [7:3] select the mode and bits [2:0] are address bits [10:8]. The mode codes are 00011 for block write, 00001 for random write, 00111 for block read and 00101 for random read, so writing 0x00 to address 0x13E is the byte string 0x19 0x3E 0x00.
- R2: Block write: the byte after the opcode is address [7:0]. The first data byte is written at that address and each later data byte at the next address, until chip-select rises.
- R3: The address in both block modes is an 11-bit counter that wraps from 0x7FF to 0x000.
- R4: Random write: after the opcode, bytes alternate as low address, then data. Each data byte is written at {opcode bits [2:0], the preceding low-address byte}.
- R5: Block read: after the address byte, the first byte returned on MISO is a dummy of 0x00. Each further byte returns the memory contents at the start address, then at start+1, and so on.
- R6: Random read: after the opcode, each low-address byte is followed by a dummy byte (MISO 0x00) and then a byte that returns the memory contents at {opcode bits [2:0], low address}. The triple may repeat any number of times in one frame.
- R7: A rise of chip-select ends the command at any point. A partly shifted byte is dropped and makes no memory access, and the next frame starts again with an opcode byte.
- R8: A first byte whose bits [7:3] match none of the four codes makes the engine ignore the rest of the frame: no memory access, and MISO stays 0.
- R9: MISO is 0 during the opcode byte, the address bytes and the write data bytes.
- R10: Each access is a one-cycle mem_req pulse with mem_we high for writes and low for reads. Read data is taken from mem_rdata one clock after the request. A block write makes one write per data byte, and a block read makes one read per byte sent after the address byte.
- R11: While reset is held, and in the cycle after it is released, mem_req and spi_miso are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_csn | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| mem_req | output | 1 | One-cycle memory access strobe |
| mem_we | output | 1 | High for a write access |
| mem_addr | output | 11 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one clock after a read request |

## Verification
The bench runs block writes and block reads across the 0x7FF boundary. A counter that saturated or carried into a twelfth bit would write or return the wrong bytes there. It checks that the dummy byte is zero in both read styles and that the first real byte comes from the start address. A design off by one in the read pipeline would return the neighbouring byte or stale data. Chip-select is dropped mid-byte and unknown opcodes are sent to show that a partial byte or a bad opcode never produces a stray write. The bench also counts read and write strobes per frame, which would expose extra or missing speculative reads.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam int BYTE_W = 8;

  // opcode prefixes (opcode bits above the embedded high address bits)
  localparam logic [4:0] PFX_BLK_WR = 5'b00011;
  localparam logic [4:0] PFX_RND_WR = 5'b00001;
  localparam logic [4:0] PFX_BLK_RD = 5'b00111;
  localparam logic [4:0] PFX_RND_RD = 5'b00101;

  typedef enum logic [3:0] {
    ST_CMD,
    ST_BW_ADDR,
    ST_BW_DATA,
    ST_RW_ADDR,
    ST_RW_DATA,
    ST_BR_ADDR,
    ST_BR_STREAM,
    ST_RR_ADDR,
    ST_RR_DUMMY,
    ST_RR_DATA,
    ST_SKIP
  } state_e;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= RST_VAL;
    else     chain_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= RST_VAL;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_mem_shifter.sv
module spi_mem_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic [BYTE_W-1:0] rx_next;

  assign rx_next = {rx_sr[BYTE_W-2:0], mosi};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q     <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else if (!active) begin
      bit_q     <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sclk_rise) begin
        rx_sr <= rx_next;
        if (bit_q == LAST_BIT) begin
          bit_q     <= '0;
          byte_done <= 1'b1;
          rx_byte   <= rx_next;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
      // the fall that closes a byte (bit counter at zero) does not shift:
      // the next byte's MSB is loaded around that time
      if (load) begin
        tx_sr <= load_data;
      end else if (sclk_fall && bit_q != '0) begin
        tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign miso = tx_sr[BYTE_W-1];

endmodule

// File: rtl/spi_mem_fsm.sv
module spi_mem_fsm
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_data,
  output state_e            state
);

  localparam int HI_W  = ADDR_W - BYTE_W;
  localparam int PFX_W = BYTE_W - HI_W;

  state_e            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              req_q;
  logic              we_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              zero_ld_q;
  logic              rd_wait_q;
  logic [PFX_W-1:0]  pfx;

  assign pfx = rx_byte[BYTE_W-1:HI_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_CMD;
      addr_q    <= '0;
      req_q     <= 1'b0;
      we_q      <= 1'b0;
      maddr_q   <= '0;
      wdata_q   <= '0;
      zero_ld_q <= 1'b0;
      rd_wait_q <= 1'b0;
    end else begin
      req_q     <= 1'b0;
      we_q      <= 1'b0;
      zero_ld_q <= 1'b0;
      rd_wait_q <= req_q & ~we_q;
      if (!active) begin
        state_q <= ST_CMD;
      end else if (byte_done) begin
        // every byte that does not launch a read queues a zero for MISO
        zero_ld_q <= 1'b1;
        unique case (state_q)
          ST_CMD: begin
            addr_q <= {rx_byte[HI_W-1:0], {BYTE_W{1'b0}}};
            if      (pfx == PFX_W'(PFX_BLK_WR)) state_q <= ST_BW_ADDR;
            else if (pfx == PFX_W'(PFX_RND_WR)) state_q <= ST_RW_ADDR;
            else if (pfx == PFX_W'(PFX_BLK_RD)) state_q <= ST_BR_ADDR;
            else if (pfx == PFX_W'(PFX_RND_RD)) state_q <= ST_RR_ADDR;
            else                                state_q <= ST_SKIP;
          end
          ST_BW_ADDR: begin
            addr_q[BYTE_W-1:0] <= rx_byte;
            state_q            <= ST_BW_DATA;
          end
          ST_BW_DATA: begin
            req_q   <= 1'b1;
            we_q    <= 1'b1;
            maddr_q <= addr_q;
            wdata_q <= rx_byte;
            addr_q  <= addr_q + 1'b1;
          end
          ST_RW_ADDR: begin
            addr_q[BYTE_W-1:0] <= rx_byte;
            state_q            <= ST_RW_DATA;
          end
          ST_RW_DATA: begin
            req_q   <= 1'b1;
            we_q    <= 1'b1;
            maddr_q <= addr_q;
            wdata_q <= rx_byte;
            state_q <= ST_RW_ADDR;
          end
          ST_BR_ADDR: begin
            addr_q[BYTE_W-1:0] <= rx_byte;
            state_q            <= ST_BR_STREAM;
          end
          ST_BR_STREAM: begin
            zero_ld_q <= 1'b0;
            req_q     <= 1'b1;
            maddr_q   <= addr_q;
            addr_q    <= addr_q + 1'b1;
          end
          ST_RR_ADDR: begin
            addr_q[BYTE_W-1:0] <= rx_byte;
            state_q            <= ST_RR_DUMMY;
          end
          ST_RR_DUMMY: begin
            zero_ld_q <= 1'b0;
            req_q     <= 1'b1;
            maddr_q   <= addr_q;
            state_q   <= ST_RR_DATA;
          end
          ST_RR_DATA: begin
            state_q <= ST_RR_ADDR;
          end
          default: begin
            state_q <= ST_SKIP;
          end
        endcase
      end
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = maddr_q;
  assign mem_wdata = wdata_q;
  assign tx_load   = zero_ld_q | rd_wait_q;
  assign tx_data   = rd_wait_q ? mem_rdata : '0;
  assign state     = state_q;

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);

  logic [2:0]        pins_s;
  logic              sclk_s;
  logic              csn_s;
  logic              mosi_s;
  logic              sclk_d;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              frame_active;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              tx_load;
  logic [BYTE_W-1:0] tx_data;
  state_e            fsm_state;

  // pin order {sclk, csn, mosi}; chip-select resets to idle (high)
  spi_mem_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) sync_i (
    .clk(clk),
    .rst(rst),
    .d  ({spi_sclk, spi_csn, spi_mosi}),
    .q  (pins_s)
  );

  assign sclk_s = pins_s[2];
  assign csn_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign sclk_rise    = sclk_s & ~sclk_d;
  assign sclk_fall    = ~sclk_s & sclk_d;
  assign frame_active = ~csn_s;

  spi_mem_shifter #(.BYTE_W(BYTE_W)) shifter_i (
    .clk      (clk),
    .rst      (rst),
    .active   (frame_active),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .mosi     (mosi_s),
    .load     (tx_load),
    .load_data(tx_data),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .miso     (spi_miso)
  );

  spi_mem_fsm #(.ADDR_W(ADDR_W)) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .active   (frame_active),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .mem_rdata(mem_rdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .tx_load  (tx_load),
    .tx_data  (tx_data),
    .state    (fsm_state)
  );

endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_csn,
  input logic              spi_miso,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input state_e            state
);

  logic [2:0]        cs_hi_cnt;
  logic              prev_bw;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_hi_cnt <= '0;
      prev_bw   <= 1'b0;
      last_addr <= '0;
    end else begin
      if (!spi_csn)               cs_hi_cnt <= '0;
      else if (cs_hi_cnt != 3'd7) cs_hi_cnt <= cs_hi_cnt + 1'b1;
      if (spi_csn) begin
        prev_bw <= 1'b0;
      end else if (mem_req && mem_we && state == ST_BW_DATA) begin
        prev_bw   <= 1'b1;
        last_addr <= mem_addr;
      end
    end
  end

  assert_req_single_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // consecutive block writes in one frame step by one, wrapping (R2, R3)
  assert_bw_step_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && state == ST_BW_DATA && prev_bw)
      |-> mem_addr == ADDR_W'(last_addr + 1'b1));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_hi_cnt >= 3'd4) |-> (!mem_req && !spi_miso));

  assert_skip_no_access_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !mem_req);

  assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req && !spi_miso));

endmodule

bind spi_mem_engine spi_mem_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .spi_csn (spi_csn),
  .spi_miso(spi_miso),
  .mem_req (mem_req),
  .mem_we  (mem_we),
  .mem_addr(mem_addr),
  .state   (fsm_state)
);

// File: tb/spi_mem_engine_tb_top.sv
`timescale 1ns/1ps
module spi_mem_engine_tb_top;

  localparam int AW   = 11;
  localparam int HALF = 8;
  localparam int MEMN = 1 << AW;
  localparam logic [4:0] P_BW = 5'b00011;
  localparam logic [4:0] P_RW = 5'b00001;
  localparam logic [4:0] P_BR = 5'b00111;
  localparam logic [4:0] P_RR = 5'b00101;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          spi_sclk = 1'b0;
  logic          spi_csn = 1'b1;
  logic          spi_mosi = 1'b0;
  logic          spi_miso;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = 8'h00;

  logic [7:0] mem_q  [MEMN];
  logic [7:0] shadow [MEMN];
  int wr_cnt = 0;
  int rd_cnt = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_mem_engine #(.ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // bench-owned synchronous memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem_q[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem_q[mem_addr];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  function automatic logic [7:0] opc(input logic [4:0] p, input logic [AW-1:0] a);
    return {p, a[10:8]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic frame_start();
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_end();
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic blk_write(input logic [AW-1:0] a, input int n, input string tag);
    logic [7:0] r, d;
    logic [AW-1:0] p;
    int w0;
    w0 = wr_cnt;
    p = a;
    frame_start();
    xfer(opc(P_BW, a), r);
    chk(r == 8'h00, "R9 miso in opcode byte", r, 0);
    xfer(a[7:0], r);
    chk(r == 8'h00, "R9 miso in address byte", r, 0);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      shadow[p] = d;
      xfer(d, r);
      if (r != 8'h00) chk(0, "R9 miso in write data byte", r, 0);
      p = p + 1'b1;
    end
    frame_end();
    chk(wr_cnt - w0 == n, "R10 block write count", wr_cnt - w0, n);
    p = a;
    for (int k = 0; k < n; k++) begin
      chk(mem_q[p] == shadow[p], tag, mem_q[p], shadow[p]);
      p = p + 1'b1;
    end
  endtask

  task automatic blk_read(input logic [AW-1:0] a, input int n, input string tag);
    logic [7:0] r;
    logic [AW-1:0] p;
    int r0;
    r0 = rd_cnt;
    p = a;
    frame_start();
    xfer(opc(P_BR, a), r);
    xfer(a[7:0], r);
    chk(r == 8'h00, "R9 miso in read address byte", r, 0);
    xfer(8'h00, r);
    chk(r == 8'h00, "R5 dummy byte", r, 0);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      chk(r == shadow[p], tag, r, shadow[p]);
      p = p + 1'b1;
    end
    frame_end();
    chk(rd_cnt - r0 == n + 1, "R10 block read count", rd_cnt - r0, n + 1);
  endtask

  task automatic rnd_write(input logic [2:0] hi, input int n);
    logic [7:0] r, d, lo;
    logic [AW-1:0] al [8];
    frame_start();
    xfer(opc(P_RW, {hi, 8'h00}), r);
    for (int k = 0; k < n; k++) begin
      lo = 8'($urandom);
      d  = 8'($urandom);
      al[k] = {hi, lo};
      shadow[{hi, lo}] = d;
      xfer(lo, r);
      xfer(d, r);
    end
    frame_end();
    for (int k = 0; k < n; k++)
      chk(mem_q[al[k]] == shadow[al[k]], "R4 random write", mem_q[al[k]], shadow[al[k]]);
  endtask

  task automatic rnd_read(input logic [2:0] hi, input int n);
    logic [7:0] r, lo;
    int r0;
    r0 = rd_cnt;
    frame_start();
    xfer(opc(P_RR, {hi, 8'h00}), r);
    for (int k = 0; k < n; k++) begin
      lo = 8'($urandom);
      xfer(lo, r);
      xfer(8'h00, r);
      chk(r == 8'h00, "R6 dummy byte", r, 0);
      xfer(8'h00, r);
      chk(r == shadow[{hi, lo}], "R6 random read data", r, shadow[{hi, lo}]);
    end
    frame_end();
    chk(rd_cnt - r0 == n, "R10 random read count", rd_cnt - r0, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int w0, r0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < MEMN; i++) begin
      mem_q[i]  = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(spi_miso == 1'b0, "R11 miso after reset", spi_miso, 0);
    chk(mem_req == 1'b0, "R11 req after reset", mem_req, 0);
    repeat (4) @(negedge clk);
    chk(wr_cnt + rd_cnt == 0, "R11 no access after reset", wr_cnt + rd_cnt, 0);

    // R1 directed example: 0x19 0x3E 0x00 writes 0x00 at 0x13E
    chk(opc(P_BW, 11'h13E) == 8'h19, "R1 opcode encoding", opc(P_BW, 11'h13E), 8'h19);
    frame_start();
    xfer(8'h19, r);
    xfer(8'h3E, r);
    xfer(8'h00, r);
    frame_end();
    shadow[11'h13E] = 8'h00;
    chk(mem_q[11'h13E] == 8'h00, "R1 example write", mem_q[11'h13E], 0);
    chk(mem_q[11'h13F] == shadow[11'h13F], "R1 neighbour untouched", mem_q[11'h13F], shadow[11'h13F]);

    // R2 block write / R5 block read
    blk_write(11'h0A0, 5, "R2 block write");
    blk_read(11'h0A0, 5, "R5 block read data");

    // R3 wrap at 0x7FF in both block modes
    blk_write(11'h7FE, 4, "R3 block write wrap");
    blk_read(11'h7FD, 5, "R3 block read wrap");

    // R4 / R6 random modes
    rnd_write(3'd5, 4);
    rnd_read(3'd5, 3);
    rnd_read(3'd1, 2);

    // R7 chip-select rises mid-byte
    w0 = wr_cnt;
    frame_start();
    xfer(opc(P_BW, 11'h200), r);
    xfer(8'h00, r);
    for (int i = 7; i >= 4; i--) begin
      spi_mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    frame_end();
    chk(wr_cnt == w0, "R7 partial byte no write", wr_cnt - w0, 0);
    chk(mem_q[11'h200] == shadow[11'h200], "R7 memory unchanged", mem_q[11'h200], shadow[11'h200]);
    blk_read(11'h200, 1, "R7 next frame decodes opcode");

    // R8 unknown opcode
    w0 = wr_cnt;
    r0 = rd_cnt;
    frame_start();
    xfer(8'hA5, r);
    for (int k = 0; k < 4; k++) begin
      xfer(8'(8'h12 + k * 8'h11), r);
      chk(r == 8'h00, "R8 miso stays zero", r, 0);
    end
    frame_end();
    chk((wr_cnt - w0) + (rd_cnt - r0) == 0, "R8 no access", (wr_cnt - w0) + (rd_cnt - r0), 0);

    // constrained random mix
    for (int it = 0; it < 24; it++) begin
      logic [AW-1:0] a;
      int n;
      a = AW'($urandom);
      n = 1 + int'($urandom % 6);
      case ($urandom % 4)
        0: blk_write(a, n, "R2 random block write");
        1: blk_read(a, n, "R5 random block read");
        2: rnd_write(a[10:8], n);
        default: rnd_read(a[10:8], n);
      endcase
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule